// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block keeps the pending-request vector for eight interrupt lines and feeds it to a downstream priority resolver. Each line is sampled on every clock. A per-line trigger-mode bit selects how the line is handled. In level mode the request simply tracks the input. In edge mode a request is captured on a low-to-high transition and stays pending until the acknowledge logic clears it. The block ignores an acknowledge for a line in level mode, so that line stays pending for as long as its source holds it high.

Each line is a four-state machine whose state is the pair {last sampled level, request}:
- `LN_IDLE`: low, nothing pending.
- `LN_PEND`: low, request latched.
- `LN_HELD`: high, request already acknowledged.
- `LN_ACTIVE`: high, request pending.

In level mode every state goes to `LN_ACTIVE` when the input is high and to `LN_IDLE` when it is low. In edge mode the transitions are:
- A high input moves `LN_IDLE` to `LN_ACTIVE`. It also moves `LN_PEND` to `LN_ACTIVE`, and this counts as a new edge.
- In `LN_ACTIVE`, a high input stays there, or drops to `LN_HELD` on an acknowledge. A low input falls to `LN_PEND`, or to `LN_IDLE` on an acknowledge.
- In `LN_PEND`, a low input stays there, or leaves for `LN_IDLE` on an acknowledge.
- `LN_HELD` stays while the input is high and returns to `LN_IDLE` when it goes low.

The trigger-mode register is written through a simple strobe. Only the bits set in a fixed per-instance parameter `WR_MASK` can be written. The default mask is 0xF8. A second instance would use 0xDE.

Top module: `irq_req_latch`

## Requirements
- R1: A line whose trigger-mode bit is 1 (level mode) shows `pend[i]` equal to the `line_in[i]` value sampled at the previous clock edge.
- R2: A line whose trigger-mode bit is 0 (edge mode) sets `pend[i]` at the edge after it samples `line_in[i]` high while the previous sample was low.
- R3: In edge mode, a pending request stays set while the input is low and no acknowledge arrives.
- R4: In edge mode, an input that stays high after its request was acknowledged does not set the request again.
- R5: In edge mode, `ack_clr[i]` clears `pend[i]` at the next edge, unless a new rising edge is sampled in the same cycle; in that case the request stays set.
- R6: In level mode, `ack_clr[i]` has no effect: a line with a high input stays pending.
- R7: A pulse on `trig_we` loads `trig_mode` with `trig_wdata & WR_MASK` at the next edge. Bit i of `trig_mode` governs line i.
- R8: Without `trig_we`, `trig_mode` keeps its value. A new mode takes effect at the edge after it is stored.
- R9: A synchronous reset clears `pend`, `trig_mode` and every line's last-level history. A line held high through reset is therefore seen as a fresh edge once reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_in | input | LINES | Request inputs, sampled each clock |
| ack_clr | input | LINES | Per-line acknowledge clear strobes |
| trig_we | input | 1 | Trigger-mode register write strobe |
| trig_wdata | input | LINES | Trigger-mode write data |
| trig_mode | output | LINES | Trigger-mode register (1 = level, 0 = edge) |
| pend | output | LINES | Pending request vector |

## Verification
Every cycle, the assertions check each line's local transition rules:
- level lines following their input;
- edge capture, retention while low, and no retrigger while held high;
- the acknowledge clearing edge requests and sparing level ones;
- the masked mode write and its hold;
- the cleared state after reset.

Some behaviours only the bench scenarios can show. One is a rising edge arriving in the same cycle as its own acknowledge. Another is a mode change dropping a latched edge request once the line becomes level sensitive. A third is a line held high through reset reappearing as a new request. The bench also checks a second instance built with a different writable mask.

// File: rtl/irl_pkg.sv
package irl_pkg;
    // Line state encoding: {last sampled level, request}
    typedef enum logic [1:0] {
        LN_IDLE   = 2'b00,
        LN_PEND   = 2'b01,
        LN_HELD   = 2'b10,
        LN_ACTIVE = 2'b11
    } line_state_e;
endpackage

// File: rtl/irl_mode_reg.sv
module irl_mode_reg #(
    parameter int          LINES   = 8,
    parameter logic [LINES-1:0] WR_MASK = 8'hF8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [LINES-1:0] wdata,
    output logic [LINES-1:0] mode_o
);
    logic [LINES-1:0] mode_q;

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= '0;
        else if (we)
            mode_q <= wdata & WR_MASK;
    end

    always_comb mode_o = mode_q;

    AST_MODE_WRITE: assert property (@(posedge clk) disable iff (rst)
        we |=> mode_o == ($past(wdata) & WR_MASK)); // R7
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(mode_o)); // R8
endmodule

// File: rtl/irl_line_cell.sv
module irl_line_cell
    import irl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    input  logic in_i,
    input  logic clr_i,
    output logic pend_o
);
    line_state_e st, nxt;
    logic        hist;

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            st <= LN_IDLE;
        else
            st <= nxt;
    end

    // Transition logic
    always_comb begin
        nxt = st;
        if (lvl_i) begin
            nxt = in_i ? LN_ACTIVE : LN_IDLE;
        end else begin
            unique case (st)
                LN_IDLE:   nxt = in_i ? LN_ACTIVE : LN_IDLE;
                LN_PEND:   nxt = in_i ? LN_ACTIVE : (clr_i ? LN_IDLE : LN_PEND);
                LN_HELD:   nxt = in_i ? LN_HELD : LN_IDLE;
                LN_ACTIVE: begin
                    if (in_i) nxt = clr_i ? LN_HELD : LN_ACTIVE;
                    else      nxt = clr_i ? LN_IDLE : LN_PEND;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        pend_o = (st == LN_PEND) || (st == LN_ACTIVE);
        hist   = (st == LN_HELD) || (st == LN_ACTIVE);
    end

    AST_LVL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        lvl_i |=> pend_o == $past(in_i)); // R1
    AST_EDGE_RISE: assert property (@(posedge clk) disable iff (rst)
        (!lvl_i && in_i && !hist) |=> pend_o); // R2
    AST_EDGE_KEEP: assert property (@(posedge clk) disable iff (rst)
        (!lvl_i && !in_i && pend_o && !clr_i) |=> pend_o); // R3
    AST_NO_RETRIG: assert property (@(posedge clk) disable iff (rst)
        (!lvl_i && in_i && hist && !pend_o) |=> !pend_o); // R4
    AST_EDGE_ACK: assert property (@(posedge clk) disable iff (rst)
        (!lvl_i && clr_i && !(in_i && !hist)) |=> !pend_o); // R5
    AST_LVL_ACK_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (lvl_i && clr_i && in_i) |=> pend_o); // R6
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
    parameter int               LINES   = 8,
    parameter logic [LINES-1:0] WR_MASK = 8'hF8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] line_in,
    input  logic [LINES-1:0] ack_clr,
    input  logic             trig_we,
    input  logic [LINES-1:0] trig_wdata,
    output logic [LINES-1:0] trig_mode,
    output logic [LINES-1:0] pend
);
    logic [LINES-1:0] mode_w;

    irl_mode_reg #(.LINES(LINES), .WR_MASK(WR_MASK)) u_mode (
        .clk    (clk),
        .rst    (rst),
        .we     (trig_we),
        .wdata  (trig_wdata),
        .mode_o (mode_w)
    );

    for (genvar i = 0; i < LINES; i++) begin : g_line
        irl_line_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .lvl_i  (mode_w[i]),
            .in_i   (line_in[i]),
            .clr_i  (ack_clr[i]),
            .pend_o (pend[i])
        );
    end

    always_comb trig_mode = mode_w;

    AST_RST_CLEARS: assert property (@(posedge clk)
        rst |=> (pend == '0) && (trig_mode == '0)); // R9
endmodule

// File: tb/irq_req_latch_test.sv
module irq_req_latch_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] line_in = '0, ack_clr = '0, trig_wdata = '0;
    logic       trig_we = 1'b0;
    logic [7:0] trig_mode, pend;

    logic       we_b = 1'b0;
    logic [7:0] wdata_b = '0, mode_b, pend_b;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    irq_req_latch uut (
        .clk(clk), .rst(rst), .line_in(line_in), .ack_clr(ack_clr),
        .trig_we(trig_we), .trig_wdata(trig_wdata),
        .trig_mode(trig_mode), .pend(pend)
    );

    irq_req_latch #(.LINES(8), .WR_MASK(8'hDE)) uut_b (
        .clk(clk), .rst(rst), .line_in(8'h00), .ack_clr(8'h00),
        .trig_we(we_b), .trig_wdata(wdata_b),
        .trig_mode(mode_b), .pend(pend_b)
    );

    // {we, wdata, line_in, ack, expected pend, expected mode}
    localparam logic [40:0] VEC [0:16] = '{
        {1'b1, 8'hFF, 8'h00, 8'h00, 8'h00, 8'hF8}, // R7 masked write
        {1'b0, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'hF8}, // R1 R2
        {1'b0, 8'h00, 8'hFF, 8'hFF, 8'hF8, 8'hF8}, // R5 R6
        {1'b0, 8'h00, 8'hFF, 8'h00, 8'hF8, 8'hF8}, // R4 no retrigger
        {1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'hF8}, // R1 level drop
        {1'b0, 8'h00, 8'h01, 8'h00, 8'h01, 8'hF8}, // R2
        {1'b0, 8'h00, 8'h00, 8'h00, 8'h01, 8'hF8}, // R3 held while low
        {1'b0, 8'h00, 8'h00, 8'h01, 8'h00, 8'hF8}, // R5 ack clears
        {1'b0, 8'h00, 8'h01, 8'h01, 8'h01, 8'hF8}, // R5 new edge wins
        {1'b1, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00}, // R7 R8
        {1'b0, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'h00}, // R2 all edge
        {1'b0, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00}, // R3
        {1'b0, 8'h00, 8'h00, 8'h0F, 8'hF0, 8'h00}, // R5 partial ack
        {1'b1, 8'hF0, 8'h00, 8'h00, 8'hF0, 8'hF0}, // R8 old mode this cycle
        {1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'hF0}, // R1 now level, low
        {1'b0, 8'h00, 8'h30, 8'h30, 8'h30, 8'hF0}, // R6 ack ignored
        {1'b0, 8'h00, 8'h30, 8'h00, 8'h30, 8'hF0}  // R8 hold
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick();
        chk("R9 reset pend", pend, 8'h00);
        chk("R9 reset mode", trig_mode, 8'h00);
        rst = 1'b0;

        for (int k = 0; k < 17; k++) begin
            trig_we    = VEC[k][40];
            trig_wdata = VEC[k][39:32];
            line_in    = VEC[k][31:24];
            ack_clr    = VEC[k][23:16];
            tick();
            chk($sformatf("row %0d pend", k), pend, VEC[k][15:8]);
            chk($sformatf("row %0d mode", k), trig_mode, VEC[k][7:0]);
        end
        trig_we = 1'b0;
        ack_clr = '0;

        // R7 second instance, mask 0xDE
        we_b = 1'b1; wdata_b = 8'hFF;
        tick();
        chk("R7 mask DE full", mode_b, 8'hDE);
        wdata_b = 8'h21;
        tick();
        chk("R7 mask DE blocked bits", mode_b, 8'h00);
        we_b = 1'b0;

        // R9 reset with inputs held high, history cleared
        line_in = 8'hFF;
        tick();
        rst = 1'b1;
        tick();
        tick();
        chk("R9 pend cleared", pend, 8'h00);
        chk("R9 mode cleared", trig_mode, 8'h00);
        rst = 1'b0;
        tick();
        chk("R9 high input is fresh edge", pend, 8'hFF);
        ack_clr = 8'hFF;
        tick();
        chk("R4 acked while high", pend, 8'h00);
        ack_clr = 8'h00;
        tick();
        chk("R4 stays clear", pend, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule